// File: doc/BRIEF.md
# Boot-Block Address Map and Protection Gate

This block decodes a 21-bit word address of a dual-bank boot-block flash array into a block number, a bank identifier and a parameter/main flag. It also decides whether a program or erase aimed at that address may proceed. The array has eight small parameter blocks of 4 K words each and 63 large main blocks of 32 K words each. A strap input picks whether the parameter blocks sit at the high end or the low end of the address space, and the block numbering follows that choice.

The block holds one protection bit per block. A protect strobe sets the bit of the currently addressed block, and a chip-unprotect strobe clears every bit in a single cycle. The final permission is layered in a fixed order. A write-protect input always locks the two outermost boot blocks. A temporary-unprotect input lifts every other block's protection. In all remaining cases the stored bit decides. An operation request aimed at a blocked address is dropped without an error. The stored bit of the addressed block can be read back as a status byte.

Top module: `bb_map_guard`

## Requirements
- R1: With `top_boot`=0, an address whose bits [20:15] are zero is a parameter block with index equal to bits [14:12] (0..7). Any other address is a main block with index bits [20:15] + 7 (8..70).
- R2: With `top_boot`=1, an address whose bits [20:15] are all ones is a parameter block with index 63 + bits [14:12] (63..70). Any other address is a main block with index equal to bits [20:15] (0..62).
- R3: `bank_id` is 0 for the 16 Mbit half that holds the parameter blocks (bit 20 = 0 for bottom boot, bit 20 = 1 for top boot) and 1 for the other half. Bank 0 therefore holds 8 parameter and 31 main blocks, and bank 1 holds 32 main blocks.
- R4: `is_param` is 1 exactly for addresses inside the eight parameter blocks.
- R5: While `wr_protect`=1, the two outermost boot blocks give `op_allowed`=0, whatever their stored bits and whatever `temp_unprot` is. These are indices 0 and 1 for bottom boot and 69 and 70 for top boot.
- R6: While `wr_protect`=0, the two outermost boot blocks follow their own stored bits like any other block.
- R7: While `temp_unprot`=1, every block gives `op_allowed`=1 except the blocks locked under R5.
- R8: With `wr_protect`=0 and `temp_unprot`=0, `op_allowed` is the inverse of the addressed block's stored bit.
- R9: `op_go` is 1 only when `op_req`=1 and `op_allowed`=1. A request to a blocked address is dropped with no other effect.
- R10: `prot_status` reads 8'h01 when the addressed block's stored bit is set and 8'h00 otherwise. It is independent of `wr_protect` and `temp_unprot`.
- R11: After reset every stored bit is clear. A cycle with `prot_set`=1 sets the addressed block's bit at that clock edge.
- R12: A cycle with `prot_clr_all`=1 clears all stored bits at that clock edge and takes precedence over a simultaneous `prot_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 21 | Word address |
| top_boot | input | 1 | 1: parameter blocks at top, 0: at bottom |
| wr_protect | input | 1 | 1 locks the two outermost boot blocks |
| temp_unprot | input | 1 | 1 lifts stored protection temporarily |
| prot_set | input | 1 | Set stored bit of addressed block |
| prot_clr_all | input | 1 | Clear all stored bits |
| op_req | input | 1 | Program or erase request at `addr` |
| blk_idx | output | 7 | Decoded block index 0..70 |
| bank_id | output | 1 | 0: boot-side bank, 1: other bank |
| is_param | output | 1 | Address is in a parameter block |
| op_allowed | output | 1 | Program/erase permitted at `addr` |
| op_go | output | 1 | Request forwarded to the array |
| prot_status | output | 8 | 01h if addressed block is protected, else 00h |

## Verification
The map and the gate are combinational from the address, so a decode fault shows up on `blk_idx`, `bank_id` or `op_allowed` in the same cycle the address is driven. A wrong stored protection bit cannot stay hidden. It appears on `prot_status` and `op_allowed` as soon as the affected block is addressed, one edge after the strobe that should have changed it. The boundary blocks are walked in both boot variants, and the protection layers are checked against each other on blocks that hold a set bit and blocks that hold a clear one.

// File: rtl/bb_map_pkg.sv
package bb_map_pkg;
  localparam int BB_ADDR_W   = 21;
  localparam int BB_MAIN_SH  = 15;
  localparam int BB_PARAM_SH = 12;
  localparam int BB_OUTER    = 2;

  localparam int BB_PSEL_W     = BB_MAIN_SH - BB_PARAM_SH;
  localparam int BB_MSEL_W     = BB_ADDR_W - BB_MAIN_SH;
  localparam int BB_PARAM_BLKS = 1 << BB_PSEL_W;
  localparam int BB_NUM_MAIN   = (1 << BB_MSEL_W) - 1;
  localparam int BB_NUM_BLK    = BB_NUM_MAIN + BB_PARAM_BLKS;
  localparam int BB_IDX_W      = $clog2(BB_NUM_BLK);

  typedef enum logic {
    BOOT_LOW  = 1'b0,
    BOOT_HIGH = 1'b1
  } boot_side_e;
endpackage

// File: rtl/bb_rst_sync.sv
module bb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/bb_blk_decode.sv
module bb_blk_decode
  import bb_map_pkg::*;
#(
  parameter int ADDR_W   = BB_ADDR_W,
  parameter int MAIN_SH  = BB_MAIN_SH,
  parameter int PARAM_SH = BB_PARAM_SH,
  parameter int OUTER_N  = BB_OUTER,
  localparam int PSEL_W  = MAIN_SH - PARAM_SH,
  localparam int MSEL_W  = ADDR_W - MAIN_SH,
  localparam int NPARAM  = 1 << PSEL_W,
  localparam int NMAIN   = (1 << MSEL_W) - 1,
  localparam int IDX_W   = $clog2(NMAIN + NPARAM)
) (
  input  logic [ADDR_W-1:PARAM_SH] addr_hi,
  input  logic                     top_boot,
  output logic [IDX_W-1:0]         blk_idx,
  output logic                     bank_id,
  output logic                     is_param,
  output logic                     is_outer
);
  boot_side_e          side;
  logic [MSEL_W-1:0]   msel;
  logic [PSEL_W-1:0]   psel;
  logic [MSEL_W-1:0]   boot_field;
  logic                outer_lo;
  logic                outer_hi;

  always_comb begin
    side       = boot_side_e'(top_boot);
    msel       = addr_hi[ADDR_W-1:MAIN_SH];
    psel       = addr_hi[MAIN_SH-1:PARAM_SH];
    boot_field = (side == BOOT_HIGH) ? {MSEL_W{1'b1}} : {MSEL_W{1'b0}};
    is_param   = (msel == boot_field);

    outer_lo = (int'(psel) < OUTER_N);
    outer_hi = (int'(psel) >= NPARAM - OUTER_N);
    is_outer = is_param && ((side == BOOT_HIGH) ? outer_hi : outer_lo);

    if (side == BOOT_HIGH) begin
      blk_idx = is_param ? IDX_W'(NMAIN) + IDX_W'(psel) : IDX_W'(msel);
      bank_id = ~addr_hi[ADDR_W-1];
    end else begin
      blk_idx = is_param ? IDX_W'(psel) : IDX_W'(msel) + IDX_W'(NPARAM - 1);
      bank_id = addr_hi[ADDR_W-1];
    end
  end
endmodule

// File: rtl/bb_prot_bits.sv
module bb_prot_bits #(
  parameter int NUM_BLK = 71,
  localparam int IDX_W  = $clog2(NUM_BLK)
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_all,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  logic [NUM_BLK-1:0] bits_q;
  logic [NUM_BLK-1:0] bits_d;
  logic               upd_en;

  generate
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_bit
      always_comb begin
        if (clr_all)
          bits_d[b] = 1'b0;
        else if (set_en && (set_idx == IDX_W'(b)))
          bits_d[b] = 1'b1;
        else
          bits_d[b] = bits_q[b];
      end
    end
  endgenerate

  assign upd_en = set_en | clr_all;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)
      bits_q <= '0;
    else if (upd_en)
      bits_q <= bits_d;
  end

  always_comb begin
    rd_bit = 1'b0;
    for (int k = 0; k < NUM_BLK; k++)
      if (rd_idx == IDX_W'(k)) rd_bit = bits_q[k];
  end
endmodule

// File: rtl/bb_prot_gate.sv
module bb_prot_gate (
  input  logic stored_bit,
  input  logic is_outer,
  input  logic wr_protect,
  input  logic temp_unprot,
  input  logic op_req,
  output logic op_allowed,
  output logic op_go
);
  logic hw_lock;
  logic soft_lock;

  always_comb begin
    hw_lock    = wr_protect & is_outer;
    soft_lock  = stored_bit & ~temp_unprot;
    op_allowed = ~(hw_lock | soft_lock);
    op_go      = op_req & op_allowed;
  end
endmodule

// File: rtl/bb_map_guard.sv
module bb_map_guard
  import bb_map_pkg::*;
#(
  parameter int ADDR_W   = BB_ADDR_W,
  parameter int MAIN_SH  = BB_MAIN_SH,
  parameter int PARAM_SH = BB_PARAM_SH,
  parameter int OUTER_N  = BB_OUTER,
  localparam int NUM_BLK = ((1 << (ADDR_W - MAIN_SH)) - 1) + (1 << (MAIN_SH - PARAM_SH)),
  localparam int IDX_W   = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              top_boot,
  input  logic              wr_protect,
  input  logic              temp_unprot,
  input  logic              prot_set,
  input  logic              prot_clr_all,
  input  logic              op_req,
  output logic [IDX_W-1:0]  blk_idx,
  output logic              bank_id,
  output logic              is_param,
  output logic              op_allowed,
  output logic              op_go,
  output logic [7:0]        prot_status
);
  logic rst_q_n;
  logic is_outer;
  logic stored_bit;

  bb_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  bb_blk_decode #(
    .ADDR_W   (ADDR_W),
    .MAIN_SH  (MAIN_SH),
    .PARAM_SH (PARAM_SH),
    .OUTER_N  (OUTER_N)
  ) u_dec (
    .addr_hi  (addr[ADDR_W-1:PARAM_SH]),
    .top_boot (top_boot),
    .blk_idx  (blk_idx),
    .bank_id  (bank_id),
    .is_param (is_param),
    .is_outer (is_outer)
  );

  bb_prot_bits #(
    .NUM_BLK (NUM_BLK)
  ) u_bits (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .set_en  (prot_set),
    .set_idx (blk_idx),
    .clr_all (prot_clr_all),
    .rd_idx  (blk_idx),
    .rd_bit  (stored_bit)
  );

  bb_prot_gate u_gate (
    .stored_bit  (stored_bit),
    .is_outer    (is_outer),
    .wr_protect  (wr_protect),
    .temp_unprot (temp_unprot),
    .op_req      (op_req),
    .op_allowed  (op_allowed),
    .op_go       (op_go)
  );

  assign prot_status = {7'b0, stored_bit};
endmodule

// File: rtl/bb_map_guard_chk.sv
module bb_map_guard_chk #(
  parameter int ADDR_W   = 21,
  parameter int MAIN_SH  = 15,
  parameter int PARAM_SH = 12,
  parameter int OUTER_N  = 2,
  parameter int NUM_BLK  = 71,
  parameter int IDX_W    = 7
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [ADDR_W-1:0] addr,
  input logic              top_boot,
  input logic              wr_protect,
  input logic              temp_unprot,
  input logic              prot_set,
  input logic              prot_clr_all,
  input logic              op_req,
  input logic [IDX_W-1:0]  blk_idx,
  input logic              is_param,
  input logic              op_allowed,
  input logic              op_go,
  input logic [7:0]        prot_status
);
  localparam int PSEL_W = MAIN_SH - PARAM_SH;
  localparam int MSEL_W = ADDR_W - MAIN_SH;

  logic [MSEL_W-1:0] m_f;
  logic [PSEL_W-1:0] p_f;
  logic              edge_blk;

  assign m_f = addr[ADDR_W-1:MAIN_SH];
  assign p_f = addr[MAIN_SH-1:PARAM_SH];
  assign edge_blk = top_boot ? ((&m_f) && (int'(p_f) >= (1 << PSEL_W) - OUTER_N))
                             : ((m_f == '0) && (int'(p_f) < OUTER_N));

  // R5
  wp_outer_lock_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_protect && edge_blk) |-> !op_allowed);

  // R7
  temp_unprot_open_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (temp_unprot && !(wr_protect && edge_blk)) |-> op_allowed);

  // R9
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    op_go |-> (op_req && op_allowed));

  // R10
  status_blocks_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (prot_status == 8'h01 && !temp_unprot) |-> !op_allowed);

  // R11
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (prot_set && !prot_clr_all) |=>
      (!$stable(addr) || !$stable(top_boot) || prot_status == 8'h01));

  // R12
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    prot_clr_all |=> (prot_status == 8'h00));

  // R4
  param_region_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((top_boot ? (&m_f) : (m_f == '0)) == is_param));

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    int'(blk_idx) < NUM_BLK);
endmodule

bind bb_map_guard bb_map_guard_chk #(
  .ADDR_W   (ADDR_W),
  .MAIN_SH  (MAIN_SH),
  .PARAM_SH (PARAM_SH),
  .OUTER_N  (OUTER_N),
  .NUM_BLK  (NUM_BLK),
  .IDX_W    (IDX_W)
) u_chk (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .addr         (addr),
  .top_boot     (top_boot),
  .wr_protect   (wr_protect),
  .temp_unprot  (temp_unprot),
  .prot_set     (prot_set),
  .prot_clr_all (prot_clr_all),
  .op_req       (op_req),
  .blk_idx      (blk_idx),
  .is_param     (is_param),
  .op_allowed   (op_allowed),
  .op_go        (op_go),
  .prot_status  (prot_status)
);

// File: tb/tb_bb_map_guard.sv
`timescale 1ns/1ps
module tb_bb_map_guard;
  logic        clk;
  logic        rst_n;
  logic [20:0] addr;
  logic        top_boot, wr_protect, temp_unprot;
  logic        prot_set, prot_clr_all, op_req;
  logic [6:0]  blk_idx;
  logic        bank_id, is_param, op_allowed, op_go;
  logic [7:0]  prot_status;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bb_map_guard dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .top_boot(top_boot),
    .wr_protect(wr_protect), .temp_unprot(temp_unprot),
    .prot_set(prot_set), .prot_clr_all(prot_clr_all), .op_req(op_req),
    .blk_idx(blk_idx), .bank_id(bank_id), .is_param(is_param),
    .op_allowed(op_allowed), .op_go(op_go), .prot_status(prot_status)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {top, addr, wp, tu, idx, bank, param, allowed}
  localparam int NV = 20;
  localparam logic [33:0] VEC [0:NV-1] = '{
    {1'b0, 21'h000000, 1'b0, 1'b0, 7'd0,  1'b0, 1'b1, 1'b1},
    {1'b0, 21'h001FFF, 1'b1, 1'b0, 7'd1,  1'b0, 1'b1, 1'b0},
    {1'b0, 21'h002000, 1'b1, 1'b0, 7'd2,  1'b0, 1'b1, 1'b1},
    {1'b0, 21'h007FFF, 1'b0, 1'b0, 7'd7,  1'b0, 1'b1, 1'b1},
    {1'b0, 21'h008000, 1'b0, 1'b0, 7'd8,  1'b0, 1'b0, 1'b1},
    {1'b0, 21'h0FFFFF, 1'b1, 1'b0, 7'd38, 1'b0, 1'b0, 1'b1},
    {1'b0, 21'h100000, 1'b0, 1'b0, 7'd39, 1'b1, 1'b0, 1'b1},
    {1'b0, 21'h1FFFFF, 1'b0, 1'b0, 7'd70, 1'b1, 1'b0, 1'b1},
    {1'b0, 21'h000000, 1'b1, 1'b1, 7'd0,  1'b0, 1'b1, 1'b0},
    {1'b0, 21'h001000, 1'b0, 1'b1, 7'd1,  1'b0, 1'b1, 1'b1},
    {1'b1, 21'h000000, 1'b1, 1'b0, 7'd0,  1'b1, 1'b0, 1'b1},
    {1'b1, 21'h0FFFFF, 1'b0, 1'b0, 7'd31, 1'b1, 1'b0, 1'b1},
    {1'b1, 21'h100000, 1'b0, 1'b0, 7'd32, 1'b0, 1'b0, 1'b1},
    {1'b1, 21'h1F7FFF, 1'b0, 1'b0, 7'd62, 1'b0, 1'b0, 1'b1},
    {1'b1, 21'h1F8000, 1'b1, 1'b0, 7'd63, 1'b0, 1'b1, 1'b1},
    {1'b1, 21'h1FC000, 1'b0, 1'b0, 7'd67, 1'b0, 1'b1, 1'b1},
    {1'b1, 21'h1FD000, 1'b1, 1'b0, 7'd68, 1'b0, 1'b1, 1'b1},
    {1'b1, 21'h1FE000, 1'b1, 1'b0, 7'd69, 1'b0, 1'b1, 1'b0},
    {1'b1, 21'h1FFFFF, 1'b1, 1'b1, 7'd70, 1'b0, 1'b1, 1'b0},
    {1'b1, 21'h1FF000, 1'b0, 1'b0, 7'd70, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic tb, input logic [20:0] a,
                       input logic wp, input logic tu);
    @(negedge clk);
    top_boot = tb; addr = a; wr_protect = wp; temp_unprot = tu;
    #1;
  endtask

  task automatic pulse(input logic s, input logic c);
    @(negedge clk);
    prot_set = s; prot_clr_all = c;
    @(negedge clk);
    prot_set = 1'b0; prot_clr_all = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; top_boot = 1'b0; wr_protect = 1'b0;
    temp_unprot = 1'b0; prot_set = 1'b0; prot_clr_all = 1'b0; op_req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state: all bits clear
    drive(1'b0, 21'h000000, 1'b0, 1'b0);
    chk("R11 reset status", prot_status, 8'h00);
    drive(1'b1, 21'h1FFFFF, 1'b0, 1'b0);
    chk("R11 reset status", prot_status, 8'h00);

    // Vector walk: R1/R2 index, R3 bank, R4 param, R5/R7 permission, R9 go
    op_req = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][33], VEC[i][32:12], VEC[i][11], VEC[i][10]);
      chk(VEC[i][33] ? "R2 index" : "R1 index", blk_idx, VEC[i][9:3]);
      chk("R3 bank", bank_id, VEC[i][2]);
      chk("R4 param", is_param, VEC[i][1]);
      chk("R5 R7 allowed", op_allowed, VEC[i][0]);
      chk("R9 go", op_go, VEC[i][0]);
    end

    // R11 set a main block, R8/R9/R10 effect
    drive(1'b0, 21'h100000, 1'b0, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R11 set status", prot_status, 8'h01);
    chk("R8 protected", op_allowed, 0);
    chk("R9 dropped", op_go, 0);
    drive(1'b0, 21'h0F8000, 1'b0, 1'b0);
    chk("R10 neighbour status", prot_status, 8'h00);
    chk("R8 neighbour", op_allowed, 1);
    drive(1'b0, 21'h100000, 1'b0, 1'b1);
    chk("R7 temp unprot", op_allowed, 1);
    chk("R10 status under tu", prot_status, 8'h01);
    drive(1'b0, 21'h100000, 1'b1, 1'b0);
    chk("R10 status under wp", prot_status, 8'h01);

    // R6 outer block follows own bit when wp low
    drive(1'b0, 21'h000000, 1'b0, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R6 own bit set", op_allowed, 0);
    drive(1'b0, 21'h001000, 1'b0, 1'b0);
    chk("R6 own bit clear", op_allowed, 1);
    drive(1'b0, 21'h001000, 1'b1, 1'b0);
    chk("R5 wp lock", op_allowed, 0);
    drive(1'b0, 21'h000000, 1'b1, 1'b1);
    chk("R5 wp beats tu", op_allowed, 0);
    drive(1'b0, 21'h000000, 1'b0, 1'b1);
    chk("R7 tu on outer", op_allowed, 1);

    // R2 top variant set
    drive(1'b1, 21'h1FF000, 1'b0, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R2 R11 top set", prot_status, 8'h01);

    // R12 clear all beats simultaneous set
    drive(1'b0, 21'h0F8000, 1'b0, 1'b0);
    pulse(1'b1, 1'b1);
    chk("R12 clr wins", prot_status, 8'h00);
    drive(1'b0, 21'h100000, 1'b0, 1'b0);
    chk("R12 cleared", prot_status, 8'h00);
    chk("R12 allowed", op_allowed, 1);
    drive(1'b0, 21'h000000, 1'b0, 1'b0);
    chk("R12 cleared outer", prot_status, 8'h00);
    drive(1'b1, 21'h1FF000, 1'b0, 1'b0);
    chk("R12 cleared top", prot_status, 8'h00);

    // R11 reset clears a set bit
    drive(1'b0, 21'h200000 - 21'h1, 1'b0, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R11 pre-reset", prot_status, 8'h01);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 after reset", prot_status, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule